// File: doc/BRIEF.md
# Interrupt Controller Programming Port

This block is the register front end of an 8-input programmable interrupt controller. A CPU reaches it over a narrow I/O bus: a chip select, a single port-select address bit, read and write strobes and an 8-bit data bus. Only the address bit picks the port, so a register pair placed anywhere in the I/O map shows up at every even/odd offset pair the decoder routes to it.

Writes run a short initialization sequence and decode operation commands. An even-port write with data bit 4 set starts initialization. The next odd-port writes load the vector base and the cascade configuration. A third odd-port write loads the mode byte, or is dropped when the opening command did not ask for one. After that, odd-port writes load the interrupt mask. Even-port writes carry either a priority/end-of-interrupt command or a read-select command. The priority command is passed on to downstream logic as a one-cycle strobe. The read-select command decides whether even-port reads return the request or the in-service register.

The request and in-service registers are inputs from the rest of the controller. Every programmed field is an output. Each clock cycle with chip select and write strobe both high counts as one write access. Reads are combinational.

Top module: `pic_prog_port`

## Requirements
- R1: An even-port write (`a0`=0) with `din[4]`=1 is taken as the opening init command at any time. In the next cycle, `cfg_init` holds the byte, `mask_o` is 0x00, `rdsel_ctl` is 0x02, even-port reads select the request register, `init_done` is 0 and the sequence waits for the vector byte.
- R2: The first odd-port write after the opening command loads `cfg_vbase`. The second loads `cfg_slave`.
- R3: The third odd-port write loads `cfg_mode` only when `cfg_init[0]` is 1; otherwise `cfg_mode` keeps its value. In both cases the sequence ends and `init_done` becomes 1.
- R4: Outside the init sequence, an odd-port write loads `mask_o`. `mask_o` changes on no other access except the opening init command.
- R5: Outside the init sequence, an even-port write with `din[4:3]`=00 drives `cmd_pri` with the byte and raises `cmd_pri_vld` for exactly the next cycle.
- R6: Outside the init sequence, an even-port write with `din[4:3]`=01 is stored in `rdsel_ctl`. If `din[1:0]` is 10, even-port reads select the request register. If it is 11, they select the in-service register. If it is 00 or 01, the previous selection is kept.
- R7: While the init sequence is in progress, an even-port write with `din[4]`=0 is rejected. `cmd_err` pulses for one cycle and no output register changes.
- R8: A read (`cs`=1, `rd`=1) returns `mask_o` at the odd port, and `irq_req` or `irq_svc` at the even port according to the selection. With no read active, `dout` is 0x00.
- R9: Reset (`rst_n`=0) leaves `mask_o`, `cfg_init`, `cfg_vbase`, `cfg_slave`, `cfg_mode` and `cmd_pri` at 0x00, `rdsel_ctl` at 0x02 with the request register selected, `init_done`, `cmd_pri_vld` and `cmd_err` at 0, and the block accepting operation commands.
- R10: A write strobe while `cs`=0 changes no output and starts no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs | input | 1 | Chip select |
| a0 | input | 1 | Port select: 0 even, 1 odd |
| rd | input | 1 | Read strobe |
| wr | input | 1 | Write strobe, one access per cycle |
| din | input | 8 | Write data |
| dout | output | 8 | Read data |
| irq_req | input | 8 | Pending request register |
| irq_svc | input | 8 | In-service register |
| mask_o | output | 8 | Interrupt mask |
| cfg_init | output | 8 | Opening init command byte |
| cfg_vbase | output | 8 | Vector base byte |
| cfg_slave | output | 8 | Cascade configuration byte |
| cfg_mode | output | 8 | Mode byte |
| rdsel_ctl | output | 8 | Last read-select command byte |
| init_done | output | 1 | Init sequence completed |
| cmd_pri | output | 8 | Last priority/EOI command byte |
| cmd_pri_vld | output | 1 | One-cycle strobe for a new priority command |
| cmd_err | output | 1 | One-cycle strobe for a rejected write |

## Verification
The bound checker verifies the following on every cycle:
- the effect of an opening init command on the mask, the read-select byte and `init_done`;
- that the mask holds between writes;
- that both strobes trace back to an even-port write of the matching class and never occur together;
- that an odd-port read returns the mask.

Only the bench's scenarios can show the following:
- the ordering of the three-step sequence;
- the conditional drop of the mode byte;
- a restart in the middle of the sequence;
- the kept selection after an OCW3 with low bits 00 or 01.

Its random traffic, checked against a reference model, covers the interleavings the directed cases miss.

// File: rtl/pic_prog_port.sv
module pic_prog_port #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs,
  input  logic          a0,
  input  logic          rd,
  input  logic          wr,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout,
  input  logic [DW-1:0] irq_req,
  input  logic [DW-1:0] irq_svc,
  output logic [DW-1:0] mask_o,
  output logic [DW-1:0] cfg_init,
  output logic [DW-1:0] cfg_vbase,
  output logic [DW-1:0] cfg_slave,
  output logic [DW-1:0] cfg_mode,
  output logic [DW-1:0] rdsel_ctl,
  output logic          init_done,
  output logic [DW-1:0] cmd_pri,
  output logic          cmd_pri_vld,
  output logic          cmd_err
);
  localparam logic [DW-1:0] RDSEL_RST = DW'(2);

  typedef enum logic [1:0] {ST_RUN, ST_VEC, ST_CAS, ST_MODE} step_t;
  step_t step;
  logic  sel_svc;

  wire wr_even  = cs & wr & ~a0;
  wire wr_odd   = cs & wr & a0;
  wire is_start = wr_even & din[4];
  wire in_seq   = (step != ST_RUN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step        <= ST_RUN;
      sel_svc     <= 1'b0;
      mask_o      <= '0;
      cfg_init    <= '0;
      cfg_vbase   <= '0;
      cfg_slave   <= '0;
      cfg_mode    <= '0;
      rdsel_ctl   <= RDSEL_RST;
      init_done   <= 1'b0;
      cmd_pri     <= '0;
      cmd_pri_vld <= 1'b0;
      cmd_err     <= 1'b0;
    end else begin
      cmd_pri_vld <= 1'b0;
      cmd_err     <= 1'b0;
      if (is_start) begin
        cfg_init  <= din;
        mask_o    <= '0;
        rdsel_ctl <= RDSEL_RST;
        sel_svc   <= 1'b0;
        init_done <= 1'b0;
        step      <= ST_VEC;
      end else if (wr_even) begin
        if (in_seq) begin
          cmd_err <= 1'b1;
        end else if (!din[3]) begin
          cmd_pri     <= din;
          cmd_pri_vld <= 1'b1;
        end else begin
          rdsel_ctl <= din;
          if (din[1]) sel_svc <= din[0];
        end
      end else if (wr_odd) begin
        case (step)
          ST_VEC: begin
            cfg_vbase <= din;
            step      <= ST_CAS;
          end
          ST_CAS: begin
            cfg_slave <= din;
            step      <= ST_MODE;
          end
          ST_MODE: begin
            if (cfg_init[0]) cfg_mode <= din;
            init_done <= 1'b1;
            step      <= ST_RUN;
          end
          default: mask_o <= din;
        endcase
      end
    end
  end

  assign dout = !(cs && rd) ? '0 :
                a0          ? mask_o :
                sel_svc     ? irq_svc : irq_req;
endmodule

module pic_prog_port_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cs,
  input logic          a0,
  input logic          rd,
  input logic          wr,
  input logic [DW-1:0] din,
  input logic [DW-1:0] dout,
  input logic [DW-1:0] mask_o,
  input logic [DW-1:0] rdsel_ctl,
  input logic          init_done,
  input logic          cmd_pri_vld,
  input logic          cmd_err
);
  AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && wr && !a0 && din[4]) |=> (mask_o == '0 && !init_done && rdsel_ctl == DW'(2))); // R1
  AST_MASK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !(cs && wr) |=> $stable(mask_o)); // R4
  AST_PRI_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_pri_vld |-> $past(cs && wr && !a0 && din[4:3] == 2'b00)); // R5
  AST_ERR_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_err |-> $past(cs && wr && !a0 && !din[4])); // R7
  AST_STROBES_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_err && cmd_pri_vld)); // R7
  AST_ODD_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && rd && a0) |-> dout == mask_o); // R8
  AST_NO_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !(cs && rd) |-> dout == '0); // R8
  AST_NOSEL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs && wr) |=> (!cmd_err && !cmd_pri_vld)); // R10
endmodule

bind pic_prog_port pic_prog_port_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs(cs), .a0(a0), .rd(rd), .wr(wr), .din(din),
  .dout(dout), .mask_o(mask_o), .rdsel_ctl(rdsel_ctl), .init_done(init_done),
  .cmd_pri_vld(cmd_pri_vld), .cmd_err(cmd_err)
);

// File: tb/tb_pic_prog_port.sv
module tb_pic_prog_port;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cs = 0, a0 = 0, rd = 0, wr = 0;
  logic [7:0] din = 0, irq_req = 0, irq_svc = 0;
  logic [7:0] dout, mask_o, cfg_init, cfg_vbase, cfg_slave, cfg_mode, rdsel_ctl, cmd_pri;
  logic init_done, cmd_pri_vld, cmd_err;

  int compared = 0, mismatched = 0;
  bit done_flag = 0;

  // reference model
  int m_step = 0;
  logic [7:0] m_mask = 0, m_init = 0, m_vb = 0, m_sl = 0, m_md = 0, m_ctl = 8'h02, e_pri = 0;
  bit m_svc = 0, m_done = 0, e_vld = 0, e_err = 0;

  always #5 clk = ~clk;

  pic_prog_port dut (
    .clk(clk), .rst_n(rst_n), .cs(cs), .a0(a0), .rd(rd), .wr(wr), .din(din),
    .dout(dout), .irq_req(irq_req), .irq_svc(irq_svc), .mask_o(mask_o),
    .cfg_init(cfg_init), .cfg_vbase(cfg_vbase), .cfg_slave(cfg_slave),
    .cfg_mode(cfg_mode), .rdsel_ctl(rdsel_ctl), .init_done(init_done),
    .cmd_pri(cmd_pri), .cmd_pri_vld(cmd_pri_vld), .cmd_err(cmd_err)
  );

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %02h expected %02h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] exp_read(bit c, bit a);
    if (!c) return 8'h00;
    if (a) return m_mask;
    return m_svc ? irq_svc : irq_req;
  endfunction

  task automatic check_all(string tag);
    chk({tag, "/R4 mask"}, mask_o, m_mask);
    chk({tag, "/R1 init"}, cfg_init, m_init);
    chk({tag, "/R2 vbase"}, cfg_vbase, m_vb);
    chk({tag, "/R2 slave"}, cfg_slave, m_sl);
    chk({tag, "/R3 mode"}, cfg_mode, m_md);
    chk({tag, "/R3 done"}, {7'd0, init_done}, {7'd0, m_done});
    chk({tag, "/R6 ctl"}, rdsel_ctl, m_ctl);
    chk({tag, "/R5 vld"}, {7'd0, cmd_pri_vld}, {7'd0, e_vld});
    chk({tag, "/R5 pri"}, cmd_pri, e_pri);
    chk({tag, "/R7 err"}, {7'd0, cmd_err}, {7'd0, e_err});
  endtask

  task automatic model_write(bit c, bit a, logic [7:0] d);
    e_vld = 0; e_err = 0;
    if (!c) return;
    if (!a && d[4]) begin
      m_init = d; m_mask = 0; m_ctl = 8'h02; m_svc = 0; m_done = 0; m_step = 1;
    end else if (!a) begin
      if (m_step != 0) e_err = 1;
      else if (!d[3]) begin e_pri = d; e_vld = 1; end
      else begin m_ctl = d; if (d[1]) m_svc = d[0]; end
    end else begin
      case (m_step)
        1: begin m_vb = d; m_step = 2; end
        2: begin m_sl = d; m_step = 3; end
        3: begin if (m_init[0]) m_md = d; m_done = 1; m_step = 0; end
        default: m_mask = d;
      endcase
    end
  endtask

  task automatic do_wr(string tag, bit c, bit a, logic [7:0] d);
    cs = c; a0 = a; din = d; wr = 1; rd = 0;
    model_write(c, a, d);
    @(negedge clk);
    cs = 0; wr = 0;
    check_all(tag);
  endtask

  task automatic idle(string tag);
    e_vld = 0; e_err = 0;
    @(negedge clk);
    check_all(tag);
  endtask

  task automatic do_rd(string tag, bit c, bit a);
    cs = c; a0 = a; rd = 1; wr = 0;
    #2;
    chk({tag, "/R8 read"}, dout, exp_read(c, a));
    @(negedge clk);
    cs = 0; rd = 0;
    e_vld = 0; e_err = 0;
  endtask

  task automatic report();
    if (!done_flag) begin
      done_flag = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    void'($urandom(32'd1234));
    irq_req = 8'h5A; irq_svc = 8'hC3;
    repeat (3) @(negedge clk);
    check_all("reset R9");
    chk("reset R9 read even", dout, 8'h00);
    rst_n = 1;
    @(negedge clk);
    do_rd("R9 even selects request", 1, 0);
    do_wr("R4 mask before init", 1, 1, 8'hF0);
    do_wr("R1 start w/ mode", 1, 0, 8'h11);
    do_rd("R1 mask cleared read", 1, 1);
    do_wr("R7 even during init", 1, 0, 8'h0B);
    idle("R7 pulse ends");
    do_wr("R2 vbase", 1, 1, 8'h20);
    do_wr("R2 slave", 1, 1, 8'h04);
    do_wr("R3 mode kept", 1, 1, 8'h05);
    do_wr("R4 mask", 1, 1, 8'h3C);
    do_wr("R5 pri cmd", 1, 0, 8'h20);
    idle("R5 one cycle");
    do_wr("R6 sel svc", 1, 0, 8'h0B);
    do_rd("R6 read svc", 1, 0);
    do_wr("R6 keep sel 00", 1, 0, 8'h08);
    do_rd("R6 still svc", 1, 0);
    do_wr("R6 keep sel 01", 1, 0, 8'h09);
    do_rd("R6 still svc 2", 1, 0);
    do_wr("R10 cs low write", 0, 1, 8'hFF);
    do_wr("R10 cs low even", 0, 0, 8'h20);
    do_rd("R8 no cs read", 0, 1);
    do_wr("R1 start no mode", 1, 0, 8'h10);
    do_rd("R1 back to request", 1, 0);
    do_wr("R2 vbase 2", 1, 1, 8'h40);
    do_wr("R1 restart mid-seq", 1, 0, 8'h12);
    do_wr("R2 vbase 3", 1, 1, 8'h48);
    do_wr("R2 slave 3", 1, 1, 8'h02);
    do_wr("R3 mode dropped", 1, 1, 8'hAA);
    do_wr("R4 mask 2", 1, 1, 8'h81);
    do_rd("R8 odd read", 1, 1);

    for (int i = 0; i < 1500; i++) begin
      int op;
      op = int'($urandom_range(0, 99));
      irq_req = 8'($urandom); irq_svc = 8'($urandom);
      if (op < 10)      do_wr("rnd R1", 1, 0, 8'($urandom) | 8'h10);
      else if (op < 45) do_wr("rnd R4", 1, 1, 8'($urandom));
      else if (op < 65) do_wr("rnd R6", 1, 0, 8'($urandom) & 8'hEF);
      else if (op < 70) do_wr("rnd R10", 0, 1'($urandom), 8'($urandom));
      else if (op < 95) do_rd("rnd R8", 1, 1'($urandom));
      else              idle("rnd idle");
    end
    report();
  end
endmodule